// File: doc/BRIEF.md
# Reloading prescaler with event counter

The block holds two counters that advance on a tick-enable input. The tick is a one-cycle strobe made elsewhere, usually at a prescale rate of 20 MHz. The first counter is a down-counter. On each tick it counts down from a reload value that software programs. The tick after the down-counter reaches zero loads the reload value back into it. That same tick advances the second counter, an up-counter that counts how many times the down-counter has expired. One expiry period is therefore the reload value plus one ticks. With a reload value of zero, the down-counter stays at zero and the up-counter advances on every tick.

Software reads and writes the reload value, the current down-count and the up-count through a small register port. The port has a byte address, a write strobe, write data and a combinational read-data output. A write to the reload value changes nothing until the next reload. A write that lands in the same cycle as a tick wins for the register it targets. The other registers still follow the tick.

Inside the down-counter path, a two-state machine records whether the count is still running or has expired:
- `ST_RUN`: the down-count is nonzero.
- `ST_EXPIRED`: the down-count is zero and the next tick will reload.

The machine has these transitions:
- `RUN_TO_EXPIRED`: a tick while the count is 1, or a software write of zero.
- `EXPIRED_TO_RUN`: a tick while the reload value is nonzero, or a software write of a nonzero count.
- `EXPIRED_HOLD`: a tick while the reload value is zero. The down-count stays at zero.
- `RUN_HOLD`: no tick and no write of the down-count.

Top module: `fpc_top`

## Requirements
- R1: While reset is asserted, the up-count, the reload value and the down-count are all zero. All three read as zero after reset is released.
- R2: On a tick with a nonzero down-count, the down-count decreases by exactly one. Without a tick or a write to it, the down-count holds its value.
- R3: On a tick with a down-count of zero, the down-count takes the reload value and the up-count increases by one on that same edge. With reload 5 and start 7, successive ticks give 6,5,4,3,2,1,0,5,4,3,2,1,0,5, and the up-count steps on the 8th and 14th tick.
- R4: With a reload value of zero, the down-count stays at zero once it gets there, and the up-count increases on every tick.
- R5: Writing the reload value leaves the current down-count unchanged. The new value is used at the next reload.
- R6: Register byte offsets are: up-count at 0x18, reload value at 0x1C, down-count at 0x20. Reads are zero-extended to the bus width. Any other address reads zero, and a write to it changes no register.
- R7: When a write and a tick occur in the same cycle, the written register takes the written value. The other registers still follow R2 to R4; for example, the up-count still steps if the down-count was zero and was overwritten.
- R8: The up-count wraps from all-ones to zero without any other effect.
- R9: Writes keep only the low CNT_W bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescale tick enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for the read and the write |
| wr_data | input | BUS_W | Write data |
| rd_data | output | BUS_W | Read data for `addr`, combinational |

## Verification
The bench builds the block with an 8-bit counter width on a 32-bit bus. At that width, the up-count reaches its wrap point after a few hundred ticks, so the wrap is exercised both directly and during random runs. The narrow counters also make the upper bus bits meaningful for checking zero-extension and truncation. Small random reload values, mostly 0 to 6, make expiries, the stuck-at-zero reload, and write/tick collisions common within a short run.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_EXPIRED = 1'b1
    } dn_state_e;

    typedef struct packed {
        logic up;
        logic rel;
        logic dn;
    } wsel_t;

endpackage

// File: rtl/fpc_regif.sv
module fpc_regif
    import fpc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BUS_W   = 32,
    parameter int ADDR_W  = 12,
    parameter int OFS_UP  = 'h18,
    parameter int OFS_REL = 'h1C,
    parameter int OFS_DN  = 'h20
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  up_val,
    input  logic [CNT_W-1:0]  rel_val,
    input  logic [CNT_W-1:0]  dn_val,
    output wsel_t             wsel,
    output logic [CNT_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rd_data
);

    localparam logic [ADDR_W-1:0] A_UP  = ADDR_W'(OFS_UP);
    localparam logic [ADDR_W-1:0] A_REL = ADDR_W'(OFS_REL);
    localparam logic [ADDR_W-1:0] A_DN  = ADDR_W'(OFS_DN);

    logic hit_up, hit_rel, hit_dn;

    always_comb begin
        hit_up  = (addr == A_UP);
        hit_rel = (addr == A_REL);
        hit_dn  = (addr == A_DN);
    end

    always_comb begin
        wsel.up  = wr_en && hit_up;
        wsel.rel = wr_en && hit_rel;
        wsel.dn  = wr_en && hit_dn;
        wdata    = wr_data[CNT_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (hit_up)  rd_data = BUS_W'(up_val);
        if (hit_rel) rd_data = BUS_W'(rel_val);
        if (hit_dn)  rd_data = BUS_W'(dn_val);
    end

    always_comb begin
        a_onehot_sel_r6 : assert ($onehot0({hit_up, hit_rel, hit_dn}))
            else $error("p_onehot_sel_r6");
    end

endmodule

// File: rtl/fpc_down.sv
module fpc_down
    import fpc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_rel,
    input  logic             wr_dn,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rel_q,
    output logic [CNT_W-1:0] dn_q,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dn_state_e        state, st_nx;
    logic [CNT_W-1:0] dn_nx;

    always_comb begin
        st_nx = state;
        dn_nx = dn_q;
        unique case (state)
            ST_RUN: begin
                if (tick) begin
                    dn_nx = dn_q - ONE;
                    if (dn_q == ONE) st_nx = ST_EXPIRED;
                end
            end
            ST_EXPIRED: begin
                if (tick) begin
                    dn_nx = rel_q;
                    if (rel_q != '0) st_nx = ST_RUN;
                end
            end
            default: st_nx = ST_EXPIRED;
        endcase
        if (wr_dn) begin
            dn_nx = wdata;
            st_nx = (wdata == '0) ? ST_EXPIRED : ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EXPIRED;
            dn_q  <= '0;
            rel_q <= '0;
        end else begin
            state <= st_nx;
            dn_q  <= dn_nx;
            if (wr_rel) rel_q <= wdata;
        end
    end

    always_comb begin
        wrap = tick && (state == ST_EXPIRED);
    end

    p_state_match_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRED) == (dn_q == '0))
        else $error("p_state_match_r2");

    p_decrement_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_dn && dn_q != '0) |=> (dn_q == $past(dn_q) - ONE))
        else $error("p_decrement_r2");

    p_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_dn) |=> $stable(dn_q))
        else $error("p_hold_r2");

    p_reload_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_dn && dn_q == '0) |=> (dn_q == $past(rel_q)))
        else $error("p_reload_r3");

    p_stick_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_dn && dn_q == '0 && rel_q == '0) |=> (dn_q == '0))
        else $error("p_stick_zero_r4");

    p_write_dn_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_dn |=> (dn_q == $past(wdata)))
        else $error("p_write_dn_r7");

endmodule

// File: rtl/fpc_up.sv
module fpc_up #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             wr_up,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] up_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     up_q <= '0;
        else if (wr_up) up_q <= wdata;
        else if (wrap)  up_q <= up_q + ONE;
    end

    p_wrap_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_up && up_q == '1) |=> (up_q == '0))
        else $error("p_wrap_zero_r8");

    p_up_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !wr_up) |=> $stable(up_q))
        else $error("p_up_hold_r3");

endmodule

// File: rtl/fpc_top.sv
module fpc_top
    import fpc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data
);

    localparam int OFS_UP  = 'h18;
    localparam int OFS_REL = 'h1C;
    localparam int OFS_DN  = 'h20;

    wsel_t            wsel;
    logic [CNT_W-1:0] wdata, up_q, rel_q, dn_q;
    logic             wrap;

    fpc_regif #(
        .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
        .OFS_UP(OFS_UP), .OFS_REL(OFS_REL), .OFS_DN(OFS_DN)
    ) u_regif (
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .up_val(up_q), .rel_val(rel_q), .dn_val(dn_q),
        .wsel(wsel), .wdata(wdata), .rd_data(rd_data)
    );

    fpc_down #(.CNT_W(CNT_W)) u_down (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_rel(wsel.rel), .wr_dn(wsel.dn), .wdata(wdata),
        .rel_q(rel_q), .dn_q(dn_q), .wrap(wrap)
    );

    fpc_up #(.CNT_W(CNT_W)) u_up (
        .clk(clk), .rst_n(rst_n), .wrap(wrap),
        .wr_up(wsel.up), .wdata(wdata), .up_q(up_q)
    );

    p_up_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dn_q == '0 && !wsel.up) |=> (up_q == $past(up_q) + CNT_W'(1)))
        else $error("p_up_step_r3");

    p_reload_write_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (wsel.rel && !wsel.dn && !tick) |=> $stable(dn_q))
        else $error("p_reload_write_r5");

    p_reset_zero_r1 : assert property (@(posedge clk)
        !rst_n |-> (up_q == '0 && rel_q == '0 && dn_q == '0))
        else $error("p_reset_zero_r1");

endmodule

// File: tb/tb_fpc_top.sv
`timescale 1ns/1ps
module tb_fpc_top;
    localparam int CW = 8;
    localparam int BW = 32;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_UP  = 12'h018;
    localparam logic [AW-1:0] A_REL = 12'h01C;
    localparam logic [AW-1:0] A_DN  = 12'h020;
    localparam logic [AW-1:0] A_BAD = 12'h024;

    logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic [BW-1:0] rd_data;

    always #2 clk = ~clk;

    fpc_top #(.CNT_W(CW), .BUS_W(BW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [CW-1:0] m_up = '0, m_rel = '0, m_dn = '0;

    task automatic chk(string req, string what, logic [BW-1:0] got, logic [BW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [BW-1:0] v);
        addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic read_all(string req);
        logic [BW-1:0] v;
        rd(A_UP, v);  chk(req, "up",     v, BW'(m_up));
        rd(A_REL, v); chk(req, "reload", v, BW'(m_rel));
        rd(A_DN, v);  chk(req, "down",   v, BW'(m_dn));
    endtask

    // Expected next state from the requirements: tick rules first, write wins (R2-R4, R7, R9)
    task automatic model(bit t, bit w, logic [AW-1:0] a, logic [BW-1:0] d);
        logic [CW-1:0] nu, nr, nd;
        nu = m_up; nr = m_rel; nd = m_dn;
        if (t) begin
            if (m_dn == '0) begin nd = m_rel; nu = m_up + 1'b1; end
            else nd = m_dn - 1'b1;
        end
        if (w) begin
            if (a == A_UP)  nu = d[CW-1:0];
            if (a == A_REL) nr = d[CW-1:0];
            if (a == A_DN)  nd = d[CW-1:0];
        end
        m_up = nu; m_rel = nr; m_dn = nd;
    endtask

    task automatic cyc(bit t, bit w, logic [AW-1:0] a, logic [BW-1:0] d);
        tick = t; wr_en = w; addr = a; wr_data = d;
        @(posedge clk);
        model(t, w, a, d);
        @(negedge clk);
        tick = 0; wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        m_up = '0; m_rel = '0; m_dn = '0;
        read_all("R1");
        rst_n = 1;
        @(negedge clk);
        read_all("R1");
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] v;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R3: reload 5 starting from 7
        cyc(0, 1, A_REL, 5);
        cyc(0, 1, A_DN, 7);
        for (int i = 1; i <= 14; i++) begin
            cyc(1, 0, A_UP, 0);
            read_all("R3");
            rd(A_DN, v);
            chk("R3", "seq down", v, (i <= 7) ? BW'(7 - i) : (i <= 13 ? BW'(13 - i) : 32'd5));
            rd(A_UP, v);
            chk("R3", "seq up", v, (i < 8) ? 32'd0 : (i < 14 ? 32'd1 : 32'd2));
        end

        // R5: reload write does not disturb count, used at next reload
        cyc(0, 1, A_REL, 2);
        rd(A_DN, v); chk("R5", "down kept", v, 32'd5);
        for (int i = 0; i < 6; i++) cyc(1, 0, A_UP, 0);
        rd(A_DN, v); chk("R5", "new reload used", v, 32'd2);

        // R4: reload zero sticks, up steps each tick
        cyc(0, 1, A_REL, 0);
        cyc(0, 1, A_DN, 1);
        cyc(0, 1, A_UP, 0);
        for (int i = 1; i <= 5; i++) begin
            cyc(1, 0, A_UP, 0);
            rd(A_DN, v); chk("R4", "down stuck", v, 32'd0);
            rd(A_UP, v); chk("R4", "up each tick", v, BW'(i - 1));
        end

        // R7: collision, down overwritten while zero; up still steps
        cyc(1, 1, A_DN, 9);
        rd(A_DN, v); chk("R7", "down written", v, 32'd9);
        rd(A_UP, v); chk("R7", "up still steps", v, 32'd5);
        cyc(1, 1, A_UP, 'h40);
        rd(A_UP, v); chk("R7", "up written", v, 32'h40);
        rd(A_DN, v); chk("R7", "down ticked", v, 32'd8);

        // R8: wrap
        cyc(0, 1, A_UP, 'hFF);
        cyc(0, 1, A_DN, 0);
        cyc(1, 0, A_UP, 0);
        rd(A_UP, v); chk("R8", "wrap", v, 32'd0);

        // R9: truncation and zero-extension
        cyc(0, 1, A_REL, 32'hABCD_1234);
        rd(A_REL, v); chk("R9", "truncate", v, 32'h34);

        // R6: bad offset
        cyc(0, 1, A_BAD, 32'h55);
        read_all("R6");
        rd(A_BAD, v); chk("R6", "bad read", v, 32'd0);

        // Random mix (R2, R3, R4, R7)
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [AW-1:0] a;
            logic [BW-1:0] d;
            r = $urandom_range(0, 3);
            a = (r == 0) ? A_UP : (r == 1) ? A_REL : (r == 2) ? A_DN : A_BAD;
            d = ($urandom_range(0, 3) == 0) ? BW'($urandom) : BW'($urandom_range(0, 6));
            cyc(1'($urandom_range(0, 1)), $urandom_range(0, 4) == 0, a, d);
            read_all("R2");
        end

        do_reset();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule